// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a 32-bit physical address onto one of eight chip-select windows. Each window has its own configuration register carrying an enable flag, a 6-bit base that sets address bits 29:24, and a 4-bit size mask. The mask admits only four patterns, which give window sizes of 16, 32, 64 or 128 MB. The base must be aligned to the chosen size. A window whose mask is illegal or whose base is misaligned decodes nothing.

A register port writes and reads the eight configuration registers and a sticky error register. An access strobe with its address goes in. One clock edge later the block drives a one-hot chip-select vector, or a miss pulse when no enabled window claims the address. Inside a window the address aliases every window-size bytes, because only the address bits kept by the mask are compared.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, the register of window 0 reads 0x00000F40 (enabled, base 0, mask 0xF). Windows 1 to 7 read 0x00000F00. The error flag is 0, and chip selects and miss are 0.
- R2: The register of window n sits at offset 0x078 + n*0x030. Only bits 0xF7F of a written value are stored and read back. Bits 5:0 are the base, bit 6 is the enable flag and bits 11:8 are the mask.
- R3: A window claims an address only if address bits 31:30 are zero, address bits 29:28 equal base bits 5:4, and address bits 27:24 equal base bits 3:0 wherever the mask bit is 1.
- R4: Mask 0xF, 0xE, 0xC and 0x8 give windows of 16, 32, 64 and 128 MB. Every address inside the window aligned at the base is claimed, and the address just past the window is not.
- R5: A window whose mask is not one of 0xF, 0xE, 0xC or 0x8 claims no address.
- R6: A window whose base bits 3:0 have a 1 where the mask has a 0 claims no address.
- R7: A window with the enable flag clear claims nothing. A rewrite of a register drops the old mapping, and the new mapping applies to strobes from the next cycle on.
- R8: When enabled windows overlap, the lowest-numbered window alone is selected. At most one chip select is ever high.
- R9: A strobe that no window claims raises miss for exactly one cycle with all chip selects low.
- R10: The error flag sets when a configuration write has bit 6 set and carries an illegal mask or a misaligned base. It stays set until a write of 1 to bit 0 of the status register at offset 0x000, which also reads the flag in bit 0. A bad pair written with bit 6 clear does not set it.
- R11: Chip selects and miss are registered. They reflect a strobe in the cycle after it and are all low in any cycle that follows no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access physical address |
| cs_sel | output | 8 | One-hot chip-select vector |
| miss | output | 1 | Strobe matched no window |
| cfg_err | output | 1 | Sticky configuration error flag |

## Verification
The bench probes each window's first and last claimed address and the address just past it for every legal mask. A decoder that compares masked-out bits would lose the upper part of large windows, and one that ignores the mask would leak past the end. It programs an illegal mask and a misaligned base. A design that skips either check would claim addresses and would leave the error flag clear. It overlaps two windows, then disables and moves them. A wrong priority or a stale mapping would then select the wrong or a vanished window. It also checks that addresses with bit 30 or 31 set miss, that miss lasts one cycle, and that the error flag survives strobes and good writes until it is explicitly cleared.

// File: rtl/cswd_pkg.sv
package cswd_pkg;
  localparam int unsigned CFG_W      = 12;
  localparam int unsigned REG_AW     = 9;
  localparam logic [REG_AW-1:0] CFG_OFS0   = 9'h078;
  localparam logic [REG_AW-1:0] CFG_STRIDE = 9'h030;
  localparam logic [REG_AW-1:0] STAT_OFS   = 9'h000;
  localparam logic [CFG_W-1:0]  KEEP_BITS  = 12'hF7F;
  localparam int unsigned EN_BIT     = 6;

  function automatic logic size_mask_ok(input logic [3:0] m);
    return (m == 4'hF) || (m == 4'hE) || (m == 4'hC) || (m == 4'h8);
  endfunction

  function automatic logic pair_ok(input logic [CFG_W-1:0] c);
    return size_mask_ok(c[11:8]) && ((c[3:0] & ~c[11:8]) == 4'h0);
  endfunction
endpackage

// File: rtl/cswd_regfile.sv
module cswd_regfile
  import cswd_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [REG_AW-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_CS-1:0][CFG_W-1:0]  cfg,
  output logic                          err
);
  logic [NUM_CS-1:0]            sel;
  logic [NUM_CS-1:0]            cfg_en;
  logic [NUM_CS-1:0][CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0]             cfg_new;
  logic                         err_q, err_d;

  assign cfg_new = wdata[CFG_W-1:0] & KEEP_BITS;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CS; gi++) begin : g_slot
      localparam logic [REG_AW-1:0] OFS = REG_AW'(CFG_OFS0 + gi * CFG_STRIDE);
      localparam logic [CFG_W-1:0]  RST = (gi == 0) ? 12'hF40 : 12'hF00;
      assign sel[gi]    = (addr == OFS);
      assign cfg_en[gi] = wr && sel[gi];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cfg_q[gi] <= RST;
        else if (cfg_en[gi])  cfg_q[gi] <= cfg_new;
      end
    end
  endgenerate

  always_comb begin
    err_d = err_q;
    if (wr && (|sel) && cfg_new[EN_BIT] && !pair_ok(cfg_new)) err_d = 1'b1;
    if (wr && (addr == STAT_OFS) && wdata[0])                 err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  always_comb begin
    rdata = '0;
    if (addr == STAT_OFS) rdata[0] = err_q;
    for (int i = 0; i < NUM_CS; i++)
      if (sel[i]) rdata[CFG_W-1:0] = cfg_q[i];
  end

  assign cfg = cfg_q;
  assign err = err_q;
endmodule

// File: rtl/cswd_window.sv
module cswd_window
  import cswd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic       usable;
  logic [3:0] diff;

  assign usable = cfg[EN_BIT] && pair_ok(cfg);
  assign diff   = (addr[27:24] ^ cfg[3:0]) & cfg[11:8];
  assign hit    = usable && (addr[ADDR_W-1:30] == '0) &&
                  (addr[29:28] == cfg[5:4]) && (diff == 4'h0);
endmodule

// File: rtl/cswd_prio.sv
module cswd_prio #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswd_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_CS-1:0] cs_sel,
  output logic              miss,
  output logic              cfg_err
);
  logic [NUM_CS-1:0][CFG_W-1:0] cfg;
  logic [NUM_CS-1:0]            req, grant;
  logic [NUM_CS-1:0]            cs_d, cs_q;
  logic                         miss_d, miss_q;

  cswd_regfile #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .err(cfg_err)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CS; gi++) begin : g_win
      cswd_window #(.ADDR_W(ADDR_W)) i_win (
        .cfg(cfg[gi]), .addr(acc_addr), .hit(req[gi])
      );
    end
  endgenerate

  cswd_prio #(.N(NUM_CS)) i_prio (.req(req), .grant(grant));

  always_comb begin
    cs_d   = acc_valid ? grant : '0;
    miss_d = acc_valid && (req == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '0;
      miss_q <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      miss_q <= miss_d;
    end
  end

  assign cs_sel = cs_q;
  assign miss   = miss_q;
endmodule

// File: rtl/cswd_checker.sv
module cswd_checker
  import cswd_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [NUM_CS-1:0] cs_sel,
  input logic              miss,
  input logic              cfg_err
);
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (cs_sel == '0));

  p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (miss || (cs_sel != '0)));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!miss && (cs_sel == '0)));

  p_high_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[ADDR_W-1:30] != '0)) |=> miss);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !(reg_wr && (reg_addr == STAT_OFS) && reg_wdata[0])) |=> cfg_err);
endmodule

bind cs_window_decoder cswd_checker #(
  .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .cs_sel(cs_sel), .miss(miss), .cfg_err(cfg_err)
);

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  cs_sel;
  logic        miss;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  logic        due = 1'b0;
  logic [11:0] mdl [8];
  logic        mdl_err;
  logic [8:0]  exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .cs_sel(cs_sel), .miss(miss), .cfg_err(cfg_err)
  );

  function automatic logic legal(input logic [11:0] c);
    logic [3:0] m;
    m = c[11:8];
    if (!(m == 4'hF || m == 4'hE || m == 4'hC || m == 4'h8)) return 1'b0;
    return (c[3:0] & ~m) == 4'h0;
  endfunction

  function automatic logic [8:0] predict(input logic [31:0] a);
    logic [11:0] c;
    for (int i = 0; i < 8; i++) begin
      c = mdl[i];
      if (c[6] && legal(c) && a[31:30] == 2'b00 && a[29:28] == c[5:4] &&
          ((a[27:24] ^ c[3:0]) & c[11:8]) == 4'h0)
        return {1'b0, 8'(1 << i)};
    end
    return {1'b1, 8'h00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) due <= acc_valid && rst_n;

  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) check("R11 unexpected result", {23'b0, miss, cs_sel}, 32'h1ff);
      else check(tag_q.pop_front(), {23'b0, miss, cs_sel}, {23'b0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    for (int i = 0; i < 8; i++)
      if (a == 9'(9'h078 + i * 9'h030)) begin
        mdl[i] = d[11:0] & 12'hF7F;
        if (d[6] && !legal(d[11:0])) mdl_err = 1'b1;
      end
    if (a == 9'h000 && d[0]) mdl_err = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic strobe(input string tag, input logic [31:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    exp_q.push_back(predict(a));
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    mdl[0] = 12'hF40;
    for (int i = 1; i < 8; i++) mdl[i] = 12'hF00;
    mdl_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 win0 reset", 9'h078, 32'hF40);
    for (int i = 1; i < 8; i++) rd("R1 winN reset", 9'(9'h078 + i * 9'h030), 32'hF00);
    check("R1 err reset", {31'b0, cfg_err}, 0);
    check("R1 outputs reset", {23'b0, miss, cs_sel}, 0);

    // R3 / R4 default window 0
    strobe("R3 base 0 low", 32'h0000_0000);
    strobe("R4 16MB top", 32'h00FF_FFFF);
    strobe("R4 16MB past", 32'h0100_0000);
    // R9 miss lasts one cycle
    @(negedge clk);
    check("R9 miss one cycle", {31'b0, miss}, 0);

    // R2 offsets and stored bits
    wr(9'h108, 32'hFFFF_FFFF);
    rd("R2 kept bits", 9'h108, 32'h0000_0F7F);
    strobe("R3 base 3F", 32'h3F80_0000);
    strobe("R3 bit30 set", 32'h7F00_0000);
    strobe("R3 bit31 set", 32'hBF00_0000);

    // R4 larger windows
    wr(9'h0D8, 32'h0000_0E46);
    strobe("R4 32MB first", 32'h0600_0000);
    strobe("R4 32MB last", 32'h07FF_FFFF);
    strobe("R4 32MB past", 32'h0800_0000);
    wr(9'h0D8, 32'h0000_0C48);
    strobe("R4 64MB last", 32'h0BFF_FFFF);
    strobe("R4 64MB past", 32'h0C00_0000);
    wr(9'h0D8, 32'h0000_0850);
    strobe("R4 128MB first", 32'h1000_0000);
    strobe("R4 128MB last", 32'h17FF_FFFF);
    strobe("R4 128MB past", 32'h1800_0000);
    drain();
    check("R10 good writes no err", {31'b0, cfg_err}, 0);

    // R5 illegal mask
    wr(9'h138, 32'h0000_0D60);
    check("R10 err on bad mask", {31'b0, cfg_err}, 1);
    strobe("R5 illegal mask", 32'h2000_0000);
    strobe("R5 illegal mask alt", 32'h2200_0000);
    drain();
    check("R10 err sticky", {31'b0, cfg_err}, 1);
    rd("R10 status read", 9'h000, 32'h1);
    wr(9'h000, 32'h0);
    check("R10 write 0 keeps", {31'b0, cfg_err}, 1);
    wr(9'h000, 32'h1);
    check("R10 clear", {31'b0, cfg_err}, 0);

    // R6 misaligned base
    wr(9'h138, 32'h0000_0E61);
    check("R10 err on misalign", {31'b0, cfg_err}, 1);
    strobe("R6 misaligned", 32'h2000_0000);
    strobe("R6 misaligned base", 32'h2100_0000);
    wr(9'h000, 32'h1);
    wr(9'h138, 32'h0000_0520);
    check("R10 disabled bad no err", {31'b0, cfg_err}, 0);

    // R8 overlap, R7 remap
    wr(9'h0A8, 32'h0000_0F40);
    strobe("R8 lowest wins", 32'h0012_3456);
    wr(9'h078, 32'h0000_0F00);
    strobe("R7 win0 disabled", 32'h0012_3456);
    wr(9'h0A8, 32'h0000_0F45);
    strobe("R7 old mapping gone", 32'h0000_0000);
    strobe("R7 new mapping", 32'h0500_0010);
    wr(9'h0A8, 32'h0000_0805);
    strobe("R7 enable clear", 32'h0500_0010);

    // R11 back-to-back and idle
    strobe("R11 b2b a", 32'h3F00_0000);
    strobe("R11 b2b b", 32'h1400_0000);
    drain();
    check("R11 idle low", {23'b0, miss, cs_sel}, 0);
    check("R10 final err", {31'b0, cfg_err}, {31'b0, mdl_err});
    drain();
    finish_run();
  end
endmodule